// File: doc/BRIEF.md
# Strap-Configured Dual-Clock Width-Converting FIFO

This block is one FIFO channel with a write side and a read side on unrelated clocks. Its operating mode is not programmed by software. It is taken from strap inputs while the active-low master reset is held low, and it stays fixed until the next master reset. The straps choose three things:

- how the read side presents data: either a plain registered read, or a mode where the head word falls through to the output on its own;
- whether the write bus is one unit or two units wide;
- whether the read bus is one unit or two units wide.

A separate strap selects the narrow-only channel arrangement. When that strap is set, both buses are one unit wide whatever their own straps say.

Storage is kept in units of `UNIT_W` bits. A wide write stores its lower half first and its upper half next. A wide read returns the older unit in its lower half. Mixed widths therefore pack and unpack in arrival order.

Each side keeps its own binary pointer. Each side sees the other side's pointer through a Gray-coded copy that moves one unit per clock, followed by a two-flop synchronizer.

Top module: `strapcfg_fifo`

## Requirements
- R1: Strap values are latched on every clock edge at which `mrst_n` is low. The last latched values set the mode until the next reset, and strap changes after reset have no effect.
- R2: After master reset, `wr_full` is 0, `rd_avail` is 0 and `rd_data` is all zeros.
- R3: When `cfg_fwft` was 0 at reset (standard read), `rd_data` changes only on the `rclk` edge after one at which both `rd_en` and `rd_avail` are 1. Otherwise it holds its value, including while the FIFO is empty. In this mode `rd_avail` means enough units are stored for one read.
- R4: When `cfg_fwft` was 1 at reset (fall-through read), the oldest word appears on `rd_data` with `rd_avail` = 1 without any `rd_en`. It stays there until an `rd_en` at an edge consumes it.
- R5: Each accepted narrow write stores `wr_data[UNIT_W-1:0]`. Each accepted wide write stores `wr_data[UNIT_W-1:0]` first and `wr_data[2*UNIT_W-1:UNIT_W]` second.
- R6: A wide read returns the older unit in `rd_data[UNIT_W-1:0]` and the newer unit in the upper half. A narrow read returns one unit in the lower half, and the upper half is zero.
- R7: When `cfg_quad` was 1 at reset, both buses act as narrow regardless of `cfg_wr_wide` and `cfg_rd_wide`. The upper half of `wr_data` is discarded.
- R8: On a wide read bus, no read takes place while fewer than two units are stored. `rd_avail` stays 0 in that case.
- R9: `wr_full` is 1 while fewer free unit slots remain than one write needs (one for narrow, two for wide). Writes offered while `wr_full` is 1 are dropped.
- R10: Every stored unit is read exactly once, in write order, across the two clock domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain; straps are latched while low |
| cfg_quad | input | 1 | Strap: 1 forces both buses to narrow |
| cfg_fwft | input | 1 | Strap: 0 standard read, 1 fall-through read |
| cfg_wr_wide | input | 1 | Strap: 1 selects a two-unit write bus |
| cfg_rd_wide | input | 1 | Strap: 1 selects a two-unit read bus |
| wr_en | input | 1 | Write request |
| wr_data | input | 2*UNIT_W | Write data; lower half only in narrow mode |
| wr_full | output | 1 | Not enough free slots for one write |
| rd_en | input | 1 | Read request (standard) or consume (fall-through) |
| rd_data | output | 2*UNIT_W | Registered read data |
| rd_avail | output | 1 | Standard: a read would succeed; fall-through: `rd_data` holds a valid word |

## Verification
The assertions assume the following about the inputs:

- the straps hold steady during every clock edge of a reset window;
- `mrst_n` stays low for several edges of both clocks;
- the requests change only away from the rising edges.

Under these conditions, the latched mode, the output register and the pointers follow only from the captured straps and the accepted requests.

The bench respects this. It moves the straps only while reset is low, and it flips them just after release, so any late strap sampling shows up as a data error. It drives requests on falling edges, offers a write only when the full flag seen at that falling edge is low, and reads only when `rd_avail` is high at a falling edge. The only exception is the deliberate overflow and empty-read probes, which the requirements define as ignored.

// File: rtl/strapcfg_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the strap-configured FIFO.
// Assumes pointer widths never exceed 32 bits.
package strapcfg_fifo_pkg;

    // Read presentation mode latched at master reset.
    typedef enum logic {
        TIMING_STD  = 1'b0,
        TIMING_FWFT = 1'b1
    } rd_timing_e;

    // A width strap only takes effect outside the narrow-only arrangement.
    function automatic logic effective_wide(input logic quad, input logic wide_strap);
        return wide_strap & ~quad;
    endfunction

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/strapcfg_fifo_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a multi-bit Gray value.
// Assumes at most one bit of d changes per source clock.
module strapcfg_fifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign value, then let it settle one more stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/strapcfg_fifo_gpub.sv
`timescale 1ns/1ps
// Publishes a binary pointer to the other domain as Gray code.
// The published copy moves at most one unit per clock, so that exactly
// one bit changes per edge even when the real pointer jumps by two.
// Assumes the target never runs ahead by more than the pointer range.
module strapcfg_fifo_gpub #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] target_bin,
    output logic [PW-1:0] gray_q
);
    import strapcfg_fifo_pkg::*;

    logic [PW-1:0] pub_bin;
    logic [PW-1:0] pub_next;

    // One-unit step toward the real pointer.
    always_comb begin
        pub_next = (pub_bin != target_bin) ? pub_bin + PW'(1) : pub_bin;
    end

    // Register the published position and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_bin <= '0;
            gray_q  <= '0;
        end else begin
            pub_bin <= pub_next;
            gray_q  <= PW'(bin_to_gray(32'(pub_next)));
        end
    end
endmodule

// File: rtl/strapcfg_fifo_store.sv
`timescale 1ns/1ps
// Unit storage: two write lanes at consecutive addresses and
// two combinational read lanes at consecutive addresses, wrapping.
// Assumes the pointer logic never lets the two lanes overlap live data.
module strapcfg_fifo_store #(
    parameter int UNIT_W = 10,
    parameter int AW     = 4
) (
    input  logic              wclk,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [AW-1:0]     waddr,
    input  logic [UNIT_W-1:0] wd_lo,
    input  logic [UNIT_W-1:0] wd_hi,
    input  logic [AW-1:0]     raddr,
    output logic [UNIT_W-1:0] rd_lo,
    output logic [UNIT_W-1:0] rd_hi
);
    localparam int DEPTH = 1 << AW;

    logic [UNIT_W-1:0] mem [DEPTH];
    logic [AW-1:0]     waddr_hi;
    logic [AW-1:0]     raddr_hi;

    // Neighbouring slot for the second half, wrapping at the top.
    always_comb begin
        waddr_hi = waddr + AW'(1);
        raddr_hi = raddr + AW'(1);
    end

    // Store one or two units per write edge.
    always_ff @(posedge wclk) begin
        if (we_lo) mem[waddr]    <= wd_lo;
        if (we_hi) mem[waddr_hi] <= wd_hi;
    end

    // Present the head unit and the one behind it.
    always_comb begin
        rd_lo = mem[raddr];
        rd_hi = mem[raddr_hi];
    end
endmodule

// File: rtl/strapcfg_fifo_wr.sv
`timescale 1ns/1ps
// Write side: latches its width at reset, splits wide words into two
// units, advances the unit pointer and raises full from a synchronized
// read pointer. Assumes rgray_sync is already in the wclk domain.
module strapcfg_fifo_wr #(
    parameter int UNIT_W = 10,
    parameter int AW     = 4
) (
    input  logic                wclk,
    input  logic                mrst_n,
    input  logic                strap_quad,
    input  logic                strap_wide,
    input  logic                wr_en,
    input  logic [2*UNIT_W-1:0] wr_data,
    input  logic [AW:0]         rgray_sync,
    output logic                wr_full,
    output logic                mem_we_lo,
    output logic                mem_we_hi,
    output logic [AW-1:0]       mem_waddr,
    output logic [UNIT_W-1:0]   mem_wd_lo,
    output logic [UNIT_W-1:0]   mem_wd_hi,
    output logic [AW:0]         wptr_bin
);
    import strapcfg_fifo_pkg::*;

    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_U = PW'(1 << AW);

    logic          wide_q;
    logic [PW-1:0] rptr_w;
    logic [PW-1:0] used;
    logic [PW-1:0] free_slots;
    logic [PW-1:0] step;
    logic          accept;

    // Latch the write width while master reset is low.
    always_ff @(posedge wclk) begin
        if (!mrst_n) wide_q <= effective_wide(strap_quad, strap_wide);
    end

    // Occupancy, full flag and the memory write lanes.
    always_comb begin
        rptr_w     = PW'(gray_to_bin(32'(rgray_sync)));
        used       = wptr_bin - rptr_w;
        free_slots = DEPTH_U - used;
        step       = wide_q ? PW'(2) : PW'(1);
        wr_full    = free_slots < step;
        accept     = wr_en && !wr_full;
        mem_we_lo  = accept;
        mem_we_hi  = accept && wide_q;
        mem_waddr  = wptr_bin[AW-1:0];
        mem_wd_lo  = wr_data[UNIT_W-1:0];
        mem_wd_hi  = wr_data[2*UNIT_W-1:UNIT_W];
    end

    // Advance by the number of units just stored.
    always_ff @(posedge wclk) begin
        if (!mrst_n)     wptr_bin <= '0;
        else if (accept) wptr_bin <= wptr_bin + step;
    end
endmodule

// File: rtl/strapcfg_fifo_rd.sv
`timescale 1ns/1ps
// Read side: latches read timing and width at reset, decides when a
// word may leave, joins two units for a wide read and holds the output
// register. Assumes wgray_sync is already in the rclk domain.
module strapcfg_fifo_rd #(
    parameter int UNIT_W = 10,
    parameter int AW     = 4
) (
    input  logic                rclk,
    input  logic                mrst_n,
    input  logic                strap_quad,
    input  logic                strap_fwft,
    input  logic                strap_wide,
    input  logic                rd_en,
    input  logic [AW:0]         wgray_sync,
    input  logic [UNIT_W-1:0]   mem_rd_lo,
    input  logic [UNIT_W-1:0]   mem_rd_hi,
    output logic [AW-1:0]       mem_raddr,
    output logic [2*UNIT_W-1:0] rd_data,
    output logic                rd_avail,
    output logic [AW:0]         rptr_bin,
    output logic [AW:0]         rd_units,
    output logic [AW:0]         rd_need,
    output logic                rd_fwft,
    output logic                rd_wide
);
    import strapcfg_fifo_pkg::*;

    localparam int PW = AW + 1;

    rd_timing_e          timing_q;
    logic                ovalid;
    logic [PW-1:0]       wptr_r;
    logic                enough;
    logic                load;
    logic [2*UNIT_W-1:0] word;

    // Latch read timing and width while master reset is low.
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            timing_q <= strap_fwft ? TIMING_FWFT : TIMING_STD;
            rd_wide  <= effective_wide(strap_quad, strap_wide);
        end
    end

    // Occupancy, read decision and word assembly.
    always_comb begin
        rd_fwft   = (timing_q == TIMING_FWFT);
        wptr_r    = PW'(gray_to_bin(32'(wgray_sync)));
        rd_units  = wptr_r - rptr_bin;
        rd_need   = rd_wide ? PW'(2) : PW'(1);
        enough    = rd_units >= rd_need;
        load      = rd_fwft ? (enough && (!ovalid || rd_en)) : (enough && rd_en);
        rd_avail  = rd_fwft ? ovalid : enough;
        mem_raddr = rptr_bin[AW-1:0];
        word      = rd_wide ? {mem_rd_hi, mem_rd_lo} : {{UNIT_W{1'b0}}, mem_rd_lo};
    end

    // Output register, validity and pointer update.
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            rd_data  <= '0;
            ovalid   <= 1'b0;
            rptr_bin <= '0;
        end else begin
            if (load) begin
                rd_data  <= word;
                rptr_bin <= rptr_bin + rd_need;
            end
            ovalid <= rd_fwft ? (load || (ovalid && !rd_en)) : 1'b0;
        end
    end
endmodule

// File: rtl/strapcfg_fifo.sv
`timescale 1ns/1ps
// Top of the strap-configured dual-clock FIFO channel. It ties the write
// side, the storage, the read side and the two pointer crossings together.
// Assumes mrst_n is held low across several edges of both clocks, with
// the straps steady during that time.
module strapcfg_fifo #(
    parameter int UNIT_W = 10,
    parameter int AW     = 4
) (
    input  logic                wclk,
    input  logic                rclk,
    input  logic                mrst_n,
    input  logic                cfg_quad,
    input  logic                cfg_fwft,
    input  logic                cfg_wr_wide,
    input  logic                cfg_rd_wide,
    input  logic                wr_en,
    input  logic [2*UNIT_W-1:0] wr_data,
    output logic                wr_full,
    input  logic                rd_en,
    output logic [2*UNIT_W-1:0] rd_data,
    output logic                rd_avail
);
    localparam int PW = AW + 1;

    logic              we_lo;
    logic              we_hi;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [UNIT_W-1:0] wd_lo;
    logic [UNIT_W-1:0] wd_hi;
    logic [UNIT_W-1:0] mrd_lo;
    logic [UNIT_W-1:0] mrd_hi;
    logic [PW-1:0]     wptr_bin;
    logic [PW-1:0]     rptr_bin;
    logic [PW-1:0]     wgray_pub;
    logic [PW-1:0]     rgray_pub;
    logic [PW-1:0]     wgray_sync;
    logic [PW-1:0]     rgray_sync;
    logic [PW-1:0]     rd_units;
    logic [PW-1:0]     rd_need;
    logic              rd_fwft;
    logic              rd_wide;

    strapcfg_fifo_wr #(.UNIT_W(UNIT_W), .AW(AW)) u_wr (
        .wclk(wclk), .mrst_n(mrst_n), .strap_quad(cfg_quad), .strap_wide(cfg_wr_wide),
        .wr_en(wr_en), .wr_data(wr_data), .rgray_sync(rgray_sync), .wr_full(wr_full),
        .mem_we_lo(we_lo), .mem_we_hi(we_hi), .mem_waddr(waddr),
        .mem_wd_lo(wd_lo), .mem_wd_hi(wd_hi), .wptr_bin(wptr_bin)
    );

    strapcfg_fifo_store #(.UNIT_W(UNIT_W), .AW(AW)) u_store (
        .wclk(wclk), .we_lo(we_lo), .we_hi(we_hi), .waddr(waddr), .wd_lo(wd_lo),
        .wd_hi(wd_hi), .raddr(raddr), .rd_lo(mrd_lo), .rd_hi(mrd_hi)
    );

    strapcfg_fifo_gpub #(.PW(PW)) u_wpub (
        .clk(wclk), .rst_n(mrst_n), .target_bin(wptr_bin), .gray_q(wgray_pub)
    );

    strapcfg_fifo_sync2 #(.W(PW)) u_wsync (
        .clk(rclk), .rst_n(mrst_n), .d(wgray_pub), .q(wgray_sync)
    );

    strapcfg_fifo_gpub #(.PW(PW)) u_rpub (
        .clk(rclk), .rst_n(mrst_n), .target_bin(rptr_bin), .gray_q(rgray_pub)
    );

    strapcfg_fifo_sync2 #(.W(PW)) u_rsync (
        .clk(wclk), .rst_n(mrst_n), .d(rgray_pub), .q(rgray_sync)
    );

    strapcfg_fifo_rd #(.UNIT_W(UNIT_W), .AW(AW)) u_rd (
        .rclk(rclk), .mrst_n(mrst_n), .strap_quad(cfg_quad), .strap_fwft(cfg_fwft),
        .strap_wide(cfg_rd_wide), .rd_en(rd_en), .wgray_sync(wgray_sync),
        .mem_rd_lo(mrd_lo), .mem_rd_hi(mrd_hi), .mem_raddr(raddr), .rd_data(rd_data),
        .rd_avail(rd_avail), .rptr_bin(rptr_bin), .rd_units(rd_units), .rd_need(rd_need),
        .rd_fwft(rd_fwft), .rd_wide(rd_wide)
    );
endmodule

// File: rtl/strapcfg_fifo_chk.sv
`timescale 1ns/1ps
// Property checker for strapcfg_fifo, attached by bind.
// Assumes straps are steady through each reset window.
module strapcfg_fifo_chk #(
    parameter int UNIT_W = 10,
    parameter int AW     = 4
) (
    input logic                wclk,
    input logic                rclk,
    input logic                mrst_n,
    input logic                wr_full,
    input logic [AW:0]         wptr_bin,
    input logic                rd_en,
    input logic                rd_avail,
    input logic [2*UNIT_W-1:0] rd_data,
    input logic [AW:0]         rptr_bin,
    input logic [AW:0]         rd_units,
    input logic [AW:0]         rd_need,
    input logic                rd_fwft,
    input logic                rd_wide
);
    assert_mode_held_R1: assert property (@(posedge rclk) disable iff (!mrst_n)
        $stable({rd_fwft, rd_wide}));

    assert_std_hold_R3: assert property (@(posedge rclk) disable iff (!mrst_n)
        (!rd_fwft && !(rd_en && rd_avail)) |=> $stable(rd_data));

    assert_fwft_hold_R4: assert property (@(posedge rclk) disable iff (!mrst_n)
        (rd_fwft && rd_avail && !rd_en) |=> (rd_avail && $stable(rd_data)));

    assert_narrow_upper_zero_R6: assert property (@(posedge rclk) disable iff (!mrst_n)
        !rd_wide |-> (rd_data[2*UNIT_W-1:UNIT_W] == '0));

    assert_no_short_read_R8: assert property (@(posedge rclk) disable iff (!mrst_n)
        (rd_units < rd_need) |=> $stable(rptr_bin));

    assert_no_overflow_R9: assert property (@(posedge wclk) disable iff (!mrst_n)
        wr_full |=> $stable(wptr_bin));
endmodule

bind strapcfg_fifo strapcfg_fifo_chk #(.UNIT_W(UNIT_W), .AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wr_full(wr_full), .wptr_bin(wptr_bin),
    .rd_en(rd_en), .rd_avail(rd_avail), .rd_data(rd_data), .rptr_bin(rptr_bin),
    .rd_units(rd_units), .rd_need(rd_need), .rd_fwft(rd_fwft), .rd_wide(rd_wide)
);

// File: tb/strapcfg_fifo_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the write driver queues expected units, the reader
// pops and compares them against rd_data.
module strapcfg_fifo_tb;
    localparam int U     = 10;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          cfg_quad = 1'b0, cfg_fwft = 1'b0, cfg_wr_wide = 1'b0, cfg_rd_wide = 1'b0;
    logic          wr_en = 1'b0;
    logic [2*U-1:0] wr_data = '0;
    logic          wr_full;
    logic          rd_en = 1'b0;
    logic [2*U-1:0] rd_data;
    logic          rd_avail;

    int            n_cmp = 0;
    int            n_bad = 0;
    logic [U-1:0]  exp_q[$];
    logic [2*U-1:0] last_rd = '0;

    always #4 wclk = ~wclk;
    always #7 rclk = ~rclk;

    strapcfg_fifo #(.UNIT_W(U), .AW(AW)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .cfg_quad(cfg_quad), .cfg_fwft(cfg_fwft),
        .cfg_wr_wide(cfg_wr_wide), .cfg_rd_wide(cfg_rd_wide), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail)
    );

    task automatic chk(input string req, input logic [2*U-1:0] act, input logic [2*U-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Master reset with the given straps, then invert straps (R1) and check R2.
    task automatic do_reset(input logic q, input logic f, input logic ww, input logic rw);
        @(negedge wclk);
        mrst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        cfg_quad = q; cfg_fwft = f; cfg_wr_wide = ww; cfg_rd_wide = rw;
        repeat (5) @(posedge rclk);
        repeat (2) @(posedge wclk);
        @(negedge wclk);
        mrst_n = 1'b1;
        cfg_quad = ~q; cfg_fwft = ~f; cfg_wr_wide = ~ww; cfg_rd_wide = ~rw;
        exp_q.delete();
        last_rd = '0;
        @(negedge rclk);
        chk("R2 rd_avail", {19'd0, rd_avail}, '0);
        chk("R2 rd_data", rd_data, '0);
        chk("R2 wr_full", {19'd0, wr_full}, '0);
    endtask

    // Driver: writes n words and queues the units expected to be stored.
    task automatic push_words(input int n, input bit wide_w, input int base);
        for (int i = 0; i < n; i++) begin
            logic [U-1:0] lo;
            logic [U-1:0] hi;
            @(negedge wclk);
            wr_en = 1'b0;
            while (wr_full) @(negedge wclk);
            lo = U'(base + i);
            hi = U'(base + i) ^ 10'h2AA;
            wr_data = {hi, lo};
            wr_en = 1'b1;
            exp_q.push_back(lo);
            if (wide_w) exp_q.push_back(hi);
        end
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    // Monitor: reads n words, pops expected units and compares.
    task automatic pull_words(input int n, input bit wide_r, input bit fwft, input string req);
        for (int i = 0; i < n; i++) begin
            logic [2*U-1:0] exp;
            int guard;
            guard = 0;
            @(negedge rclk);
            while (!rd_avail && guard < 3000) begin
                @(negedge rclk);
                guard++;
            end
            if (guard >= 3000 || exp_q.size() < (wide_r ? 2 : 1)) begin
                chk({req, " stalled"}, {19'd0, rd_avail}, 20'd1);
                return;
            end
            exp = '0;
            exp[U-1:0] = exp_q.pop_front();
            if (wide_r) exp[2*U-1:U] = exp_q.pop_front();
            if (fwft) begin
                chk(req, rd_data, exp);
                rd_en = 1'b1;
                @(negedge rclk);
                rd_en = 1'b0;
            end else begin
                rd_en = 1'b1;
                @(negedge rclk);
                rd_en = 1'b0;
                chk(req, rd_data, exp);
            end
            last_rd = exp;
        end
    endtask

    bit finished = 1'b0;

    initial begin
        #1000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // T1: standard, narrow/narrow; empty reads do nothing (R3).
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge rclk); rd_en = 1'b1;
        repeat (5) @(negedge rclk);
        rd_en = 1'b0;
        chk("R3 empty read data", rd_data, '0);
        chk("R3 empty read avail", {19'd0, rd_avail}, '0);
        fork
            push_words(5, 1'b0, 16'h010);
            pull_words(5, 1'b0, 1'b0, "R3/R10 std narrow");
        join
        repeat (6) @(negedge rclk);
        chk("R3 hold after read", rd_data, last_rd);

        // T2: fall-through, narrow/narrow; first word falls through (R1/R4).
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        push_words(1, 1'b0, 16'h155);
        repeat (15) @(negedge rclk);
        chk("R1/R4 fall-through avail", {19'd0, rd_avail}, 20'd1);
        chk("R1/R4 fall-through data", rd_data, 20'h00155);
        pull_words(1, 1'b0, 1'b1, "R4 consume");
        fork
            push_words(20, 1'b0, 16'h020);
            pull_words(20, 1'b0, 1'b1, "R4/R10 fwft narrow");
        join

        // T3: standard, wide write, narrow read: lower half first (R5).
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        fork
            push_words(6, 1'b1, 16'h040);
            pull_words(12, 1'b0, 1'b0, "R5/R6 wide-in narrow-out");
        join

        // T4: fall-through, narrow write, wide read; needs two units (R8).
        do_reset(1'b0, 1'b1, 1'b0, 1'b1);
        push_words(1, 1'b0, 16'h0A1);
        repeat (15) @(negedge rclk);
        chk("R8 one unit blocks wide read", {19'd0, rd_avail}, '0);
        push_words(1, 1'b0, 16'h0B2);
        repeat (15) @(negedge rclk);
        chk("R8/R6 two units joined", rd_data, {10'h0B2, 10'h0A1});
        pull_words(1, 1'b0 | 1'b1, 1'b1, "R6 consume pair");
        fork
            push_words(10, 1'b0, 16'h060);
            pull_words(5, 1'b1, 1'b1, "R6/R10 narrow-in wide-out");
        join

        // T5: fall-through, wide/wide.
        do_reset(1'b0, 1'b1, 1'b1, 1'b1);
        fork
            push_words(8, 1'b1, 16'h080);
            pull_words(8, 1'b1, 1'b1, "R5/R6 wide/wide");
        join

        // T6: narrow-only strap overrides both width straps (R7).
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        fork
            push_words(4, 1'b0, 16'h0C0);
            pull_words(4, 1'b0, 1'b0, "R7 forced narrow");
        join

        // T7: narrow fill to full, overflow writes dropped (R9).
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        push_words(DEPTH, 1'b0, 16'h100);
        chk("R9 full after depth units", {19'd0, wr_full}, 20'd1);
        @(negedge wclk); wr_data = 20'hFFFFF; wr_en = 1'b1;
        repeat (2) @(negedge wclk);
        wr_en = 1'b0;
        pull_words(DEPTH, 1'b0, 1'b0, "R9/R10 drain after overflow");
        repeat (25) @(negedge rclk);
        chk("R9 overflow word not stored", {19'd0, rd_avail}, '0);

        // T8: wide writes fill to full with two-slot need (R9).
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        push_words(DEPTH / 2, 1'b1, 16'h140);
        chk("R9 full after wide fill", {19'd0, wr_full}, 20'd1);
        pull_words(DEPTH, 1'b0, 1'b0, "R9/R10 drain wide fill");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule